// File: doc/BRIEF.md
# MII Management Register Bridge

This block lets a host drive a PHY management bus through a handful of byte-wide registers. The host loads a PHY register number, then either loads two data bytes (storing the high byte launches a write frame) or sets a read command bit (which launches a read frame). A read frame returns its 16-bit result in two read-data registers. A status register reports the engine state: busy, scan selected, and read data pending. A scan command bit makes the block read the selected PHY register over and over and refresh the read-data registers after each frame.

Management frames use the usual serial format. Every frame starts with 32 ones. After that come a start pair, an opcode, a 5-bit PHY address, a 5-bit register number, a turnaround pair and 16 data bits. The management clock comes from dividing the system clock. The data line changes only after a falling management-clock edge, and incoming data is taken in on rising edges. The data pin is split into an output, an output-enable and an input.

Top module: `mdio_reg_bridge`

## Requirements
- R1: After a synchronous active-low reset, mdc and mdio_oe are 0, and the status, command, address, write-data and read-data registers all read 0.
- R2: In bank 2, the PHY register number is at offset 0x14 (5 bits; a read returns zeros above bit 4), the command is at 0x12 (bits 1:0), the write data low byte is at 0x16 and the high byte is at 0x17. All of these read back what was written. Status is at offset 0x0A in bank 3. Any other bank or offset reads 0, and writes to it change nothing.
- R3: A write to offset 0x17 while idle stores the byte and starts a write frame at that clock edge. Busy reads 1 from the next cycle.
- R4: A write frame sends, MSB first: 32 ones, 01, opcode 01, PHY_ADDR, the register number, turnaround 10, then {high byte, low byte}.
- R5: mdc is low while idle and starts low. Each half period lasts DIV_HALF system clocks. mdio_out changes only at falling mdc edges. A frame occupies exactly 128*DIV_HALF cycles, and busy clears at the falling edge that ends bit 63.
- R6: A read frame uses opcode 10. mdio_oe is released from the turnaround (bit 46) to the end of the frame. The last 16 bits are sampled on rising mdc edges, MSB first. The result appears at offset 0x18 (low byte) and 0x19 (high byte) when the frame ends.
- R7: Command bit 0 starts a read only when a write changes it from 0 to 1. It stays set until the host clears it, and writing 1 again while it is set starts nothing.
- R8: Status bit 0 is busy and bit 1 mirrors command bit 1. Bit 2 is 1 from the start of each read frame until its data is stored.
- R9: While command bit 1 is set, a new read frame starts one cycle after each frame ends, and the read data is refreshed after every frame. Once the bit is cleared, no new frame starts.
- R10: A launch request (a write to 0x17, or a 0-to-1 write of command bit 0) that arrives while busy reads 1 starts no frame. The register is still updated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_bank | input | 2 | Register bank select |
| host_addr | input | 5 | Register offset within the bank |
| host_wdata | input | 8 | Host write data |
| host_we | input | 1 | Host write strobe, one cycle per write |
| host_rdata | output | 8 | Combinational read data for host_bank/host_addr |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Management data output |
| mdio_oe | output | 1 | Management data output enable |
| mdio_in | input | 1 | Management data input |

## Verification
The end of a frame and a new launch request can land in the same cycle. Busy still reads 1 in the last cycle of a frame, so a write to offset 0x17 that arrives in that cycle must be dropped, and the same write one cycle later must start a frame. The bench uses its reference model to find the last frame cycle, issues the write exactly there, and then repeats it in the next cycle. The per-cycle comparison of the pins and the status register shows whether each write was dropped or accepted. The same boundary comes up again in scan mode, where the restart lands one cycle after the previous frame ends.

// File: rtl/mdio_bridge_pkg.sv
// Shared constants and the frame builder for the management bridge.
// Assumes 64-bit frames with a full 32-bit preamble.
package mdio_bridge_pkg;

    localparam logic [1:0] BANK_MII  = 2'd2;
    localparam logic [1:0] BANK_STAT = 2'd3;

    localparam logic [4:0] OFS_CMD   = 5'h12;
    localparam logic [4:0] OFS_PREG  = 5'h14;
    localparam logic [4:0] OFS_WDL   = 5'h16;
    localparam logic [4:0] OFS_WDH   = 5'h17;
    localparam logic [4:0] OFS_RDL   = 5'h18;
    localparam logic [4:0] OFS_RDH   = 5'h19;
    localparam logic [4:0] OFS_STAT  = 5'h0A;

    localparam int FRAME_BITS = 64;
    localparam int TA_BIT     = 46;
    localparam int DATA_BIT   = 48;

    // Build the serial frame, MSB sent first.
    function automatic logic [63:0] build_frame(input logic       rd,
                                                input logic [4:0] phy,
                                                input logic [4:0] preg,
                                                input logic [15:0] data);
        logic [1:0]  op;
        logic [1:0]  ta;
        logic [15:0] dfield;
        op     = rd ? 2'b10 : 2'b01;
        ta     = rd ? 2'b11 : 2'b10;
        dfield = rd ? 16'hFFFF : data;
        return {32'hFFFF_FFFF, 2'b01, op, phy, preg, ta, dfield};
    endfunction

endpackage

// File: rtl/mdio_clk_div.sv
// Management clock generator: while enabled, toggles mdc every DIV_HALF
// system clocks, starting from low. Reports the cycle whose closing edge
// makes mdc rise or fall. Assumes DIV_HALF >= 1.
module mdio_clk_div #(
    parameter int unsigned DIV_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic mdc,
    output logic rise,
    output logic fall
);
    localparam int CNT_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV_HALF - 1);

    logic [CNT_W-1:0] cnt;
    logic             at_edge;

    assign at_edge = en && (cnt == CNT_LAST);
    assign rise    = at_edge && !mdc;
    assign fall    = at_edge && mdc;

    // Half-period counter and clock toggle.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (at_edge) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_frame_engine.sv
// Serial frame engine: on start, loads a read or write frame and shifts it
// out on falling mdc edges. For reads it samples the last 16 bits on rising
// edges. Assumes start is asserted only while busy is low.
module mdio_frame_engine
    import mdio_bridge_pkg::*;
#(
    parameter logic [4:0] PHY_ADDR = 5'h01
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        start_read,
    input  logic [4:0]  preg,
    input  logic [15:0] wdata,
    input  logic        rise,
    input  logic        fall,
    input  logic        mdio_in,
    output logic        busy,
    output logic        nvalid,
    output logic        mdio_out,
    output logic        mdio_oe,
    output logic [15:0] rd_data
);
    localparam logic [5:0] IDX_LAST    = 6'(FRAME_BITS - 1);
    localparam logic [5:0] IDX_PRE_TA  = 6'(TA_BIT - 1);
    localparam logic [5:0] IDX_DATA    = 6'(DATA_BIT);

    logic [63:0] shreg;
    logic [5:0]  idx;
    logic        is_rd;
    logic [15:0] cap;

    assign mdio_out = shreg[63];

    // Frame sequencing, shifting, sampling and result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            nvalid  <= 1'b0;
            mdio_oe <= 1'b0;
            shreg   <= '0;
            idx     <= '0;
            is_rd   <= 1'b0;
            cap     <= '0;
            rd_data <= '0;
        end else if (!busy) begin
            if (start) begin
                busy    <= 1'b1;
                is_rd   <= start_read;
                nvalid  <= start_read;
                shreg   <= build_frame(start_read, PHY_ADDR, preg, wdata);
                idx     <= '0;
                mdio_oe <= 1'b1;
            end
        end else begin
            if (rise && is_rd && (idx >= IDX_DATA)) begin
                cap <= {cap[14:0], mdio_in};
            end
            if (fall) begin
                if (idx == IDX_LAST) begin
                    busy    <= 1'b0;
                    mdio_oe <= 1'b0;
                    if (is_rd) begin
                        rd_data <= cap;
                        nvalid  <= 1'b0;
                    end
                end else begin
                    idx     <= idx + 1'b1;
                    shreg   <= {shreg[62:0], 1'b0};
                    mdio_oe <= !(is_rd && (idx >= IDX_PRE_TA));
                end
            end
        end
    end
endmodule

// File: rtl/mdio_host_regs.sv
// Host register file: holds the PHY register number, command and write
// data, decodes launch requests (high byte write, read command edge, scan)
// and builds the combinational read mux. Assumes one host write per cycle.
module mdio_host_regs
    import mdio_bridge_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  host_bank,
    input  logic [4:0]  host_addr,
    input  logic [7:0]  host_wdata,
    input  logic        host_we,
    output logic [7:0]  host_rdata,
    input  logic        busy,
    input  logic        nvalid,
    input  logic [15:0] rd_data,
    output logic        start,
    output logic        start_read,
    output logic [4:0]  preg,
    output logic [15:0] wdata16
);
    logic [1:0] cmd_q;
    logic [7:0] wdl_q;
    logic [7:0] wdh_q;
    logic       mii_we;
    logic       wr_launch;
    logic       rd_launch;
    logic       scan_launch;

    assign mii_we      = host_we && (host_bank == BANK_MII);
    assign wr_launch   = mii_we && (host_addr == OFS_WDH) && !busy;
    assign rd_launch   = mii_we && (host_addr == OFS_CMD) && host_wdata[0]
                         && !cmd_q[0] && !busy;
    assign scan_launch = cmd_q[1] && !busy;
    assign start       = wr_launch || rd_launch || scan_launch;
    assign start_read  = !wr_launch;
    assign wdata16     = {host_wdata, wdl_q};

    // Host-writable register storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
            preg  <= '0;
            wdl_q <= '0;
            wdh_q <= '0;
        end else if (mii_we) begin
            case (host_addr)
                OFS_CMD:  cmd_q <= host_wdata[1:0];
                OFS_PREG: preg  <= host_wdata[4:0];
                OFS_WDL:  wdl_q <= host_wdata;
                OFS_WDH:  wdh_q <= host_wdata;
                default:  ;
            endcase
        end
    end

    // Read mux over both banks.
    always_comb begin
        host_rdata = '0;
        if (host_bank == BANK_MII) begin
            case (host_addr)
                OFS_CMD:  host_rdata = {6'b0, cmd_q};
                OFS_PREG: host_rdata = {3'b0, preg};
                OFS_WDL:  host_rdata = wdl_q;
                OFS_WDH:  host_rdata = wdh_q;
                OFS_RDL:  host_rdata = rd_data[7:0];
                OFS_RDH:  host_rdata = rd_data[15:8];
                default:  host_rdata = '0;
            endcase
        end else if (host_bank == BANK_STAT && host_addr == OFS_STAT) begin
            host_rdata = {5'b0, nvalid, cmd_q[1], busy};
        end
    end
endmodule

// File: rtl/mdio_reg_bridge.sv
// Top of the management bridge: host registers, clock divider and frame
// engine. Assumes mdio_in is synchronous to clk or already synchronised.
module mdio_reg_bridge #(
    parameter int unsigned DIV_HALF = 2,
    parameter logic [4:0]  PHY_ADDR = 5'h01
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] host_bank,
    input  logic [4:0] host_addr,
    input  logic [7:0] host_wdata,
    input  logic       host_we,
    output logic [7:0] host_rdata,
    output logic       mdc,
    output logic       mdio_out,
    output logic       mdio_oe,
    input  logic       mdio_in
);
    logic        eng_busy;
    logic        eng_nvalid;
    logic [15:0] eng_rd_data;
    logic        go;
    logic        go_read;
    logic [4:0]  preg;
    logic [15:0] wdata16;
    logic        mdc_rise;
    logic        mdc_fall;

    mdio_host_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_bank  (host_bank),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_we    (host_we),
        .host_rdata (host_rdata),
        .busy       (eng_busy),
        .nvalid     (eng_nvalid),
        .rd_data    (eng_rd_data),
        .start      (go),
        .start_read (go_read),
        .preg       (preg),
        .wdata16    (wdata16)
    );

    mdio_clk_div #(.DIV_HALF(DIV_HALF)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (eng_busy),
        .mdc   (mdc),
        .rise  (mdc_rise),
        .fall  (mdc_fall)
    );

    mdio_frame_engine #(.PHY_ADDR(PHY_ADDR)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (go),
        .start_read (go_read),
        .preg       (preg),
        .wdata      (wdata16),
        .rise       (mdc_rise),
        .fall       (mdc_fall),
        .mdio_in    (mdio_in),
        .busy       (eng_busy),
        .nvalid     (eng_nvalid),
        .mdio_out   (mdio_out),
        .mdio_oe    (mdio_oe),
        .rd_data    (eng_rd_data)
    );
endmodule

// File: rtl/mdio_bridge_chk.sv
// Protocol checker for the management bridge, bound to the top module.
module mdio_bridge_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic nvalid,
    input logic mdc,
    input logic mdio_out,
    input logic mdio_oe
);
    // R5: the clock rests low whenever no frame is running
    a_r5_mdc_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

    // R5: the data line never changes at a rising clock edge
    a_r5_out_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> $stable(mdio_out));

    // R6: the line is driven only inside a frame
    a_r6_oe_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe |-> busy);

    // R8: the pending flag only exists during a read frame
    a_r8_nvalid_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        nvalid |-> busy);

    // R3: a frame opens with mdc low and a driven preamble one
    a_r3_frame_opening: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (!mdc && mdio_oe && mdio_out));
endmodule

bind mdio_reg_bridge mdio_bridge_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (eng_busy),
    .nvalid   (eng_nvalid),
    .mdc      (mdc),
    .mdio_out (mdio_out),
    .mdio_oe  (mdio_oe)
);

// File: tb/mdio_reg_bridge_tb_top.sv
// Bench: a behavioural cycle model, compared with the pins and the host read
// port on every clock, plus directed checks at the boundaries.
module mdio_reg_bridge_tb_top;
    localparam int H        = 2;
    localparam int FRAME_CYC = 128 * H;
    localparam logic [4:0] PHY = 5'h01;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] host_bank = 2'd3;
    logic [4:0] host_addr = 5'h0A;
    logic [7:0] host_wdata = 8'h00;
    logic       host_we = 1'b0;
    logic [7:0] host_rdata;
    logic       mdc, mdio_out, mdio_oe;
    logic       mdio_in = 1'b1;

    int checks = 0;
    int errors = 0;
    bit started = 0;
    bit finished = 0;

    // reference model state
    bit          m_active;
    int          m_k;
    bit          m_read;
    logic [63:0] m_frame;
    logic [15:0] m_phy;
    logic [15:0] m_rdata;
    bit          m_nvalid;
    logic [1:0]  m_cmd;
    logic [4:0]  m_addr;
    logic [7:0]  m_wdl, m_wdh;
    logic [15:0] phy_val = 16'h0000;

    always #2 clk = ~clk;

    mdio_reg_bridge #(.DIV_HALF(H), .PHY_ADDR(PHY)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_bank(host_bank), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_we(host_we), .host_rdata(host_rdata),
        .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in));

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic launch(input bit rd, input logic [4:0] ra, input logic [15:0] d);
        m_active = 1; m_k = 0; m_read = rd; m_nvalid = rd; m_phy = phy_val;
        m_frame = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), PHY, ra,
                   (rd ? 2'b11 : 2'b10), (rd ? 16'hFFFF : d)};
    endtask

    // Reference model, one step per clock edge.
    always @(posedge clk) begin
        bit         bb;
        logic [1:0] cb;
        logic [4:0] ab;
        logic [7:0] wl;
        bit         w2;
        if (!rst_n) begin
            m_active = 0; m_k = 0; m_read = 0; m_frame = '0; m_phy = '0;
            m_rdata = '0; m_nvalid = 0; m_cmd = '0; m_addr = '0; m_wdl = '0; m_wdh = '0;
        end else begin
            bb = m_active; cb = m_cmd; ab = m_addr; wl = m_wdl;
            w2 = host_we && host_bank == 2'd2;
            if (m_active) begin
                m_k++;
                if (m_k == FRAME_CYC) begin
                    m_active = 0;
                    if (m_read) begin m_rdata = m_phy; m_nvalid = 0; end
                end
            end
            if (w2) begin
                case (host_addr)
                    5'h12: m_cmd = host_wdata[1:0];
                    5'h14: m_addr = host_wdata[4:0];
                    5'h16: m_wdl = host_wdata;
                    5'h17: m_wdh = host_wdata;
                    default: ;
                endcase
            end
            if (!bb) begin
                if (w2 && host_addr == 5'h17) launch(0, ab, {host_wdata, wl});
                else if (w2 && host_addr == 5'h12 && host_wdata[0] && !cb[0]) launch(1, ab, 16'h0);
                else if (cb[1]) launch(1, ab, 16'h0);
            end
        end
        started = 1;
    end

    function automatic logic [7:0] exp_rdata(input logic [1:0] b, input logic [4:0] a);
        if (b == 2'd2) begin
            case (a)
                5'h12: return {6'b0, m_cmd};
                5'h14: return {3'b0, m_addr};
                5'h16: return m_wdl;
                5'h17: return m_wdh;
                5'h18: return m_rdata[7:0];
                5'h19: return m_rdata[15:8];
                default: return 8'h00;
            endcase
        end
        if (b == 2'd3 && a == 5'h0A) return {5'b0, m_nvalid, m_cmd[1], m_active};
        return 8'h00;
    endfunction

    // PHY model: drives read data bits, MSB first.
    always @(negedge clk) begin
        int bitn;
        bitn = (m_k / H) / 2;
        if (m_active && m_read && bitn >= 48) mdio_in <= m_phy[63 - bitn];
        else mdio_in <= 1'b1;
    end

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        int  half, bitn;
        bit  e_mdc, e_oe;
        string tag;
        #1;
        if (started) begin
            half = m_k / H; bitn = half / 2;
            e_mdc = m_active && (half % 2 == 1);
            e_oe  = m_active && !(m_read && bitn >= 46);
            chk(mdc == e_mdc, "R5", "mdc", 32'(mdc), 32'(e_mdc));
            chk(mdio_oe == e_oe, "R6", "mdio_oe", 32'(mdio_oe), 32'(e_oe));
            if (e_oe && m_active)
                chk(mdio_out == m_frame[63 - bitn], "R4", "mdio_out",
                    32'(mdio_out), 32'(m_frame[63 - bitn]));
            if (host_bank == 2'd2 && (host_addr == 5'h18 || host_addr == 5'h19)) tag = "R6";
            else if (host_bank == 2'd3 && host_addr == 5'h0A) tag = "R8";
            else tag = "R2";
            chk(host_rdata == exp_rdata(host_bank, host_addr), tag, "host_rdata",
                32'(host_rdata), 32'(exp_rdata(host_bank, host_addr)));
        end
    end

    task automatic wr_now(input logic [1:0] b, input logic [4:0] a, input logic [7:0] d);
        host_bank = b; host_addr = a; host_wdata = d; host_we = 1'b1;
        @(negedge clk);
        host_we = 1'b0; host_bank = 2'd3; host_addr = 5'h0A;
    endtask

    task automatic wr(input logic [1:0] b, input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_now(b, a, d);
    endtask

    task automatic rd_chk(input logic [1:0] b, input logic [4:0] a,
                          input logic [7:0] exp, input string tag);
        @(negedge clk);
        host_bank = b; host_addr = a;
        #1;
        chk(host_rdata == exp, tag, "directed read", 32'(host_rdata), 32'(exp));
        @(negedge clk);
        host_bank = 2'd3; host_addr = 5'h0A;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (m_active) @(negedge clk);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        rd_chk(2'd3, 5'h0A, 8'h00, "R1");
        rd_chk(2'd2, 5'h18, 8'h00, "R1");
        rd_chk(2'd2, 5'h12, 8'h00, "R1");
        chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1", "pins idle", {30'b0, mdc, mdio_oe}, 32'h0);

        // R2: register decode and readback
        wr(2'd2, 5'h14, 8'hEB);
        rd_chk(2'd2, 5'h14, 8'h0B, "R2");
        wr(2'd2, 5'h16, 8'h5A);
        rd_chk(2'd2, 5'h16, 8'h5A, "R2");
        wr(2'd0, 5'h14, 8'h07);
        rd_chk(2'd2, 5'h14, 8'h0B, "R2");
        rd_chk(2'd0, 5'h14, 8'h00, "R2");
        rd_chk(2'd2, 5'h13, 8'h00, "R2");

        // R3/R4: write frame, then R10 requests during it
        wr(2'd2, 5'h17, 8'hC3);
        rd_chk(2'd3, 5'h0A, 8'h01, "R3");
        wr(2'd2, 5'h12, 8'h01);
        rd_chk(2'd2, 5'h12, 8'h01, "R10");
        wait_idle();
        rd_chk(2'd3, 5'h0A, 8'h00, "R10");
        wr(2'd2, 5'h12, 8'h00);

        // R10: launch in the last frame cycle is dropped, next cycle accepted
        wr(2'd2, 5'h17, 8'h3C);
        @(negedge clk);
        while (!(m_active && m_k == FRAME_CYC - 1)) @(negedge clk);
        wr_now(2'd2, 5'h17, 8'h99);
        chk(m_active == 0, "R10", "model idle after drop", 32'(m_active), 32'h0);
        wr_now(2'd2, 5'h17, 8'h66);
        rd_chk(2'd3, 5'h0A, 8'h01, "R10");
        wait_idle();

        // R6/R8: read frame
        phy_val = 16'hA5C3;
        wr(2'd2, 5'h12, 8'h01);
        rd_chk(2'd3, 5'h0A, 8'h05, "R8");
        wait_idle();
        rd_chk(2'd2, 5'h18, 8'hC3, "R6");
        rd_chk(2'd2, 5'h19, 8'hA5, "R6");
        rd_chk(2'd3, 5'h0A, 8'h00, "R8");

        // R7: rewriting a set read bit starts nothing
        wr(2'd2, 5'h12, 8'h01);
        rd_chk(2'd3, 5'h0A, 8'h00, "R7");
        rd_chk(2'd2, 5'h12, 8'h01, "R7");
        wr(2'd2, 5'h12, 8'h00);

        // R9: scan repeats with fresh data
        phy_val = 16'h1234;
        wr(2'd2, 5'h12, 8'h02);
        for (int f = 0; f < 3; f++) begin
            logic [15:0] expv;
            while (!m_active) @(negedge clk);
            expv = phy_val;
            phy_val = phy_val + 16'h1111;
            while (m_active) @(negedge clk);
            rd_chk(2'd2, 5'h18, expv[7:0], "R9");
            rd_chk(2'd2, 5'h19, expv[15:8], "R9");
        end
        wr(2'd2, 5'h12, 8'h00);
        wait_idle();
        repeat (4) @(negedge clk);
        rd_chk(2'd3, 5'h0A, 8'h00, "R9");

        finished = 1;
        summary();
        $finish;
    end
endmodule